// File: doc/BRIEF.md
# Byte-Serial Instruction Length Decoder

This block finds where each variable-length instruction starts and ends in a stream of instruction bytes. It takes one byte per cycle over a valid/ready handshake. A small state machine places each byte in one field: prefix, opcode, addressing byte, scale-index byte, displacement or immediate. The size of every field is settled only by the bytes ahead of it. Prefixes set the operand and address sizes, the opcode says whether an addressing byte and an immediate follow, and the addressing byte says whether a scale-index byte and a displacement follow. The total length is therefore only known once the last byte has arrived.

When an instruction completes, the block gives a one-cycle completion pulse with the total length, the byte offset of each field present, and the displacement and immediate sizes. An instruction that needs more than 15 bytes gives a fault pulse instead. In both cases the next byte starts a new instruction. The opcode table covers a reduced subset: one-byte opcodes plus a two-byte escape. There is no back-pressure from the block, because it can take a byte on every cycle after reset. An upstream source that stops driving valid simply stalls the decoder, which keeps its partial state.

Top module: `ild_len_decoder`

## Requirements
- R1: `in_ready` is low while reset is asserted and high on every cycle after the first clock edge out of reset. A byte is consumed only on a cycle where `in_valid` and `in_ready` are both high. Cycles without a consumed byte change no decode state and produce no pulse.
- R2: The bytes 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2 and 0xF3 are prefixes when they arrive before the opcode. Any number of them may precede an opcode. The opcode offset reported equals the number of prefixes.
- R3: An opcode byte 0x0F is an escape, and one more opcode byte follows it. For that second byte, values 0x80 to 0x8F carry a full immediate and no addressing byte. Every other value carries an addressing byte and no immediate.
- R4: For a one-byte opcode:
  - In 0x00 to 0x3F, the low three bits select the format: values 0 to 3 have an addressing byte, 4 has a 1-byte immediate, 5 has a full immediate, and 6 or 7 stand alone.
  - 0x80, 0x83 and 0xC6 have an addressing byte and a 1-byte immediate.
  - 0x81 and 0xC7 have an addressing byte and a full immediate.
  - 0x84 to 0x8F have only an addressing byte.
  - 0xB0 to 0xB7 and 0xEB have a 1-byte immediate.
  - 0xB8 to 0xBF, 0xE8 and 0xE9 have a full immediate.
  - Every other opcode is a single byte.
- R5: In the addressing byte, bits 7:6 form the mode and bits 2:0 form the register-or-memory field.
  - A scale-index byte follows when the mode is not 3 and the field equals 4. The scale-index byte never adds a displacement.
  - Mode 1 adds a 1-byte displacement.
  - Mode 2 adds a full displacement, and so does mode 0 with the field equal to 5.
  - Mode 3 adds no displacement.
- R6: A full displacement is 4 bytes, or 2 bytes when a 0x67 prefix is present.
- R7: A full immediate is 4 bytes, or 2 bytes when a 0x66 prefix is present.
- R8: `done_o` pulses for exactly one cycle, on the cycle after the last byte of an instruction is consumed. It then carries:
  - the total length, and the offsets of the opcode, addressing, scale-index, displacement and immediate fields, where offset 0 is the first byte;
  - the presence flags and both sizes.
  
  An absent field reports offset 0, flag 0 and size 0. `done_o` and `fault_o` are never high together.
- R9: An instruction of exactly 15 bytes completes normally. If a 16th byte is consumed for the same instruction, that byte is discarded and `fault_o` pulses on the next cycle instead of `done_o`.
- R10: After a completion or a fault, the next consumed byte is decoded as the first byte of a new instruction, with no prefix carried over.
- R11: After reset, `done_o`, `fault_o` and all field outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Instruction stream byte |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle over-length fault pulse |
| len_o | output | 4 | Instruction length in bytes |
| op_off_o | output | 4 | Offset of the first opcode byte (equals the prefix count) |
| modrm_off_o | output | 4 | Offset of the addressing byte |
| sib_off_o | output | 4 | Offset of the scale-index byte |
| disp_off_o | output | 4 | Offset of the first displacement byte |
| imm_off_o | output | 4 | Offset of the first immediate byte |
| has_modrm_o | output | 1 | Addressing byte present |
| has_sib_o | output | 1 | Scale-index byte present |
| disp_len_o | output | 3 | Displacement size in bytes |
| imm_len_o | output | 3 | Immediate size in bytes |

## Verification
Each field boundary is decided by state left behind by earlier bytes. A wrong sticky prefix flag, a wrong countdown value or a wrong state transition therefore moves the completion pulse by one or more bytes. Such an error shows up as a wrong length or wrong offsets on the very next `done_o`. Because the boundary then lands mid-instruction, the following instructions are also mis-framed until a fault or a lucky realignment. The stimulus chains instructions back to back with random valid gaps, so a framing slip is seen at once as a mismatch on the next completion. The length limit is driven from both sides: exactly 15 bytes, and 16 bytes reached through prefixes alone and through an immediate.

// File: rtl/ild_pkg.sv
package ild_pkg;
  typedef enum logic [2:0] {
    ST_PFX, ST_OP2, ST_MODRM, ST_SIB, ST_DISP, ST_IMM
  } ild_state_e;

  typedef enum logic [1:0] {
    IMM_NONE, IMM_BYTE, IMM_FULL
  } imm_kind_e;
endpackage

// File: rtl/ild_prefix_class.sv
module ild_prefix_class (
  input  logic [7:0] byte_i,
  output logic       is_pfx_o,
  output logic       is_opsz_o,
  output logic       is_adsz_o
);
  always_comb begin
    is_opsz_o = (byte_i == 8'h66);
    is_adsz_o = (byte_i == 8'h67);
    is_pfx_o  = is_opsz_o || is_adsz_o ||
                (byte_i inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
                                8'hF0, 8'hF2, 8'hF3});
  end
endmodule

// File: rtl/ild_opcode_table.sv
module ild_opcode_table
  import ild_pkg::*;
(
  input  logic [7:0] op_i,
  input  logic       escaped_i,
  output logic       has_modrm_o,
  output imm_kind_e  imm_kind_o
);
  always_comb begin
    has_modrm_o = 1'b0;
    imm_kind_o  = IMM_NONE;
    if (escaped_i) begin
      if (op_i[7:4] == 4'h8) imm_kind_o = IMM_FULL;
      else                   has_modrm_o = 1'b1;
    end else if (op_i[7:6] == 2'b00) begin
      case (op_i[2:0])
        3'd0, 3'd1, 3'd2, 3'd3: has_modrm_o = 1'b1;
        3'd4:                   imm_kind_o  = IMM_BYTE;
        3'd5:                   imm_kind_o  = IMM_FULL;
        default:                imm_kind_o  = IMM_NONE;
      endcase
    end else if (op_i inside {8'h80, 8'h83, 8'hC6}) begin
      has_modrm_o = 1'b1;
      imm_kind_o  = IMM_BYTE;
    end else if (op_i inside {8'h81, 8'hC7}) begin
      has_modrm_o = 1'b1;
      imm_kind_o  = IMM_FULL;
    end else if (op_i inside {[8'h84:8'h8F]}) begin
      has_modrm_o = 1'b1;
    end else if (op_i inside {[8'hB0:8'hB7], 8'hEB}) begin
      imm_kind_o = IMM_BYTE;
    end else if (op_i inside {[8'hB8:8'hBF], 8'hE8, 8'hE9}) begin
      imm_kind_o = IMM_FULL;
    end
  end
endmodule

// File: rtl/ild_addr_form.sv
module ild_addr_form #(
  parameter int FULL_DISP = 4,
  parameter int HALF_DISP = 2
) (
  input  logic [7:0] modrm_i,
  input  logic       adsz_i,
  output logic       has_sib_o,
  output logic [2:0] disp_len_o
);
  logic [1:0] mode;
  logic [2:0] rm;
  always_comb begin
    mode = modrm_i[7:6];
    rm   = modrm_i[2:0];
    has_sib_o = (mode != 2'd3) && (rm == 3'd4);
    if (mode == 2'd1)
      disp_len_o = 3'd1;
    else if (mode == 2'd2 || (mode == 2'd0 && rm == 3'd5))
      disp_len_o = adsz_i ? 3'(HALF_DISP) : 3'(FULL_DISP);
    else
      disp_len_o = 3'd0;
  end
endmodule

// File: rtl/ild_len_decoder.sv
module ild_len_decoder
  import ild_pkg::*;
#(
  parameter int MAX_LEN   = 15,
  parameter int FULL_IMM  = 4,
  parameter int HALF_IMM  = 2,
  parameter int FULL_DISP = 4,
  parameter int HALF_DISP = 2,
  parameter int LW        = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_byte,
  output logic          done_o,
  output logic          fault_o,
  output logic [LW-1:0] len_o,
  output logic [LW-1:0] op_off_o,
  output logic [LW-1:0] modrm_off_o,
  output logic [LW-1:0] sib_off_o,
  output logic [LW-1:0] disp_off_o,
  output logic [LW-1:0] imm_off_o,
  output logic          has_modrm_o,
  output logic          has_sib_o,
  output logic [2:0]    disp_len_o,
  output logic [2:0]    imm_len_o
);
  localparam logic [LW-1:0] LIMIT = LW'(MAX_LEN);

  ild_state_e  st_q, st_d;
  logic [LW-1:0] cnt_q, cnt_d, op_off_q, op_off_d, mo_off_q, mo_off_d;
  logic [LW-1:0] sib_off_q, sib_off_d, dsp_off_q, dsp_off_d, imm_off_q, imm_off_d;
  logic        opsz_q, opsz_d, adsz_q, adsz_d;
  logic        hm_q, hm_d, hs_q, hs_d;
  logic [2:0]  dl_q, dl_d, il_q, il_d, rem_q, rem_d;
  logic        ready_q, acc, fin, flt;
  logic        go_op, go_addr, go_imm;

  logic        is_pfx, is_opsz, is_adsz, tbl_modrm, af_sib;
  imm_kind_e   tbl_imm;
  logic [2:0]  af_disp;

  ild_prefix_class u_pfx (
    .byte_i(in_byte), .is_pfx_o(is_pfx), .is_opsz_o(is_opsz), .is_adsz_o(is_adsz)
  );
  ild_opcode_table u_tbl (
    .op_i(in_byte), .escaped_i(st_q == ST_OP2),
    .has_modrm_o(tbl_modrm), .imm_kind_o(tbl_imm)
  );
  ild_addr_form #(.FULL_DISP(FULL_DISP), .HALF_DISP(HALF_DISP)) u_af (
    .modrm_i(in_byte), .adsz_i(adsz_q), .has_sib_o(af_sib), .disp_len_o(af_disp)
  );

  assign in_ready = ready_q;
  assign acc      = in_valid && ready_q;

  always_comb begin
    st_d = st_q;  cnt_d = cnt_q;  op_off_d = op_off_q;  mo_off_d = mo_off_q;
    sib_off_d = sib_off_q;  dsp_off_d = dsp_off_q;  imm_off_d = imm_off_q;
    opsz_d = opsz_q;  adsz_d = adsz_q;  hm_d = hm_q;  hs_d = hs_q;
    dl_d = dl_q;  il_d = il_q;  rem_d = rem_q;
    fin = 1'b0;  flt = 1'b0;  go_op = 1'b0;  go_addr = 1'b0;  go_imm = 1'b0;
    if (acc) begin
      if (cnt_q == LIMIT) begin
        flt = 1'b1;
      end else begin
        cnt_d = cnt_q + LW'(1);
        case (st_q)
          ST_PFX: begin
            if (is_pfx) begin
              opsz_d = opsz_q | is_opsz;
              adsz_d = adsz_q | is_adsz;
            end else begin
              op_off_d = cnt_q;
              if (in_byte == 8'h0F) st_d = ST_OP2;
              else                  go_op = 1'b1;
            end
          end
          ST_OP2:   go_op = 1'b1;
          ST_MODRM: begin
            mo_off_d = cnt_q;
            hs_d     = af_sib;
            dl_d     = af_disp;
            if (af_sib) st_d = ST_SIB;
            else        go_addr = 1'b1;
          end
          ST_SIB: begin
            sib_off_d = cnt_q;
            go_addr   = 1'b1;
          end
          ST_DISP: begin
            if (rem_q == 3'd1) go_imm = 1'b1;
            else               rem_d = rem_q - 3'd1;
          end
          ST_IMM: begin
            if (rem_q == 3'd1) fin = 1'b1;
            else               rem_d = rem_q - 3'd1;
          end
          default: st_d = ST_PFX;
        endcase
        if (go_op) begin
          hm_d = tbl_modrm;
          case (tbl_imm)
            IMM_BYTE: il_d = 3'd1;
            IMM_FULL: il_d = opsz_q ? 3'(HALF_IMM) : 3'(FULL_IMM);
            default:  il_d = 3'd0;
          endcase
          if (tbl_modrm) st_d = ST_MODRM;
          else           go_imm = 1'b1;
        end
        if (go_addr) begin
          if (dl_d != 3'd0) begin
            st_d = ST_DISP;  dsp_off_d = cnt_q + LW'(1);  rem_d = dl_d;
          end else begin
            go_imm = 1'b1;
          end
        end
        if (go_imm) begin
          if (il_d != 3'd0) begin
            st_d = ST_IMM;  imm_off_d = cnt_q + LW'(1);  rem_d = il_d;
          end else begin
            fin = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;  st_q <= ST_PFX;  cnt_q <= '0;
      op_off_q <= '0;  mo_off_q <= '0;  sib_off_q <= '0;  dsp_off_q <= '0;  imm_off_q <= '0;
      opsz_q <= 1'b0;  adsz_q <= 1'b0;  hm_q <= 1'b0;  hs_q <= 1'b0;
      dl_q <= '0;  il_q <= '0;  rem_q <= '0;
      done_o <= 1'b0;  fault_o <= 1'b0;  len_o <= '0;  op_off_o <= '0;
      modrm_off_o <= '0;  sib_off_o <= '0;  disp_off_o <= '0;  imm_off_o <= '0;
      has_modrm_o <= 1'b0;  has_sib_o <= 1'b0;  disp_len_o <= '0;  imm_len_o <= '0;
    end else begin
      ready_q <= 1'b1;
      done_o  <= fin;
      fault_o <= flt;
      if (fin) begin
        len_o <= cnt_d;  op_off_o <= op_off_d;  modrm_off_o <= mo_off_d;
        sib_off_o <= sib_off_d;  disp_off_o <= dsp_off_d;  imm_off_o <= imm_off_d;
        has_modrm_o <= hm_d;  has_sib_o <= hs_d;  disp_len_o <= dl_d;  imm_len_o <= il_d;
      end
      if (fin || flt) begin
        st_q <= ST_PFX;  cnt_q <= '0;
        op_off_q <= '0;  mo_off_q <= '0;  sib_off_q <= '0;  dsp_off_q <= '0;  imm_off_q <= '0;
        opsz_q <= 1'b0;  adsz_q <= 1'b0;  hm_q <= 1'b0;  hs_q <= 1'b0;
        dl_q <= '0;  il_q <= '0;  rem_q <= '0;
      end else begin
        st_q <= st_d;  cnt_q <= cnt_d;
        op_off_q <= op_off_d;  mo_off_q <= mo_off_d;  sib_off_q <= sib_off_d;
        dsp_off_q <= dsp_off_d;  imm_off_q <= imm_off_d;
        opsz_q <= opsz_d;  adsz_q <= adsz_d;  hm_q <= hm_d;  hs_q <= hs_d;
        dl_q <= dl_d;  il_q <= il_d;  rem_q <= rem_d;
      end
    end
  end

  // R1: ready is up on every cycle after the first clock edge out of reset
  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  // R1: a cycle that consumes no byte leaves the byte count unchanged
  assert_idle_holds_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(cnt_q));

  // R8: completion and fault are never reported together
  assert_done_fault_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o));

  // R8: a reported length always extends past the opcode offset
  assert_len_covers_opcode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (len_o > op_off_o));

  // R5: a scale-index byte comes right after an addressing byte
  assert_sib_follows_modrm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && has_sib_o) |-> (has_modrm_o && sib_off_o == modrm_off_o + LW'(1)));

  // R9: a fault only follows a byte consumed with the limit already reached
  assert_fault_at_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> ($past(cnt_q) == LIMIT && $past(acc)));

  // R10: every completion or fault leaves the walker expecting a fresh instruction
  assert_fresh_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fault_o) |-> (cnt_q == '0 && st_q == ST_PFX && !opsz_q && !adsz_q));
endmodule

// File: tb/tb_ild_len_decoder.sv
module tb_ild_len_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_ready, done_o, fault_o, has_modrm_o, has_sib_o;
  logic [3:0] len_o, op_off_o, modrm_off_o, sib_off_o, disp_off_o, imm_off_o;
  logic [2:0] disp_len_o, imm_len_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] ib [0:15];
  int e_len, e_op, e_mo, e_sib, e_dsp, e_imm, e_hm, e_hs, e_dl, e_il;

  always #2.5 clk = ~clk;

  ild_len_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .done_o(done_o), .fault_o(fault_o), .len_o(len_o), .op_off_o(op_off_o),
    .modrm_off_o(modrm_off_o), .sib_off_o(sib_off_o), .disp_off_o(disp_off_o),
    .imm_off_o(imm_off_o), .has_modrm_o(has_modrm_o), .has_sib_o(has_sib_o),
    .disp_len_o(disp_len_o), .imm_len_o(imm_len_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit is_pfx(input logic [7:0] b);
    return b inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66, 8'h67,
                     8'hF0, 8'hF2, 8'hF3};
  endfunction

  function automatic logic [7:0] at(input int p);
    return (p < 16) ? ib[p] : 8'h00;
  endfunction

  // Reference model of R2..R7 walking the byte buffer; e_len > 15 means a fault.
  task automatic ref_decode();
    int p = 0;
    bit osz = 0, asz = 0;
    int ik = 0;
    logic [7:0] op, m;
    e_mo = 0; e_sib = 0; e_dsp = 0; e_imm = 0; e_hm = 0; e_hs = 0; e_dl = 0; e_il = 0;
    while (p < 16 && is_pfx(at(p))) begin
      if (at(p) == 8'h66) osz = 1;
      if (at(p) == 8'h67) asz = 1;
      p++;
    end
    e_op = p;
    op = at(p);
    p++;
    if (op == 8'h0F) begin
      op = at(p); p++;
      if (op >= 8'h80 && op <= 8'h8F) ik = 2; else e_hm = 1;
    end else if (op < 8'h40) begin
      if (op[2:0] <= 3) e_hm = 1; else if (op[2:0] == 4) ik = 1; else if (op[2:0] == 5) ik = 2;
    end else if (op == 8'h80 || op == 8'h83 || op == 8'hC6) begin e_hm = 1; ik = 1; end
    else if (op == 8'h81 || op == 8'hC7) begin e_hm = 1; ik = 2; end
    else if (op >= 8'h84 && op <= 8'h8F) e_hm = 1;
    else if ((op >= 8'hB0 && op <= 8'hB7) || op == 8'hEB) ik = 1;
    else if ((op >= 8'hB8 && op <= 8'hBF) || op == 8'hE8 || op == 8'hE9) ik = 2;
    if (e_hm == 1) begin
      e_mo = p; m = at(p); p++;
      if (m[7:6] != 3 && m[2:0] == 4) begin e_hs = 1; e_sib = p; p++; end
      if (m[7:6] == 1) e_dl = 1;
      else if (m[7:6] == 2 || (m[7:6] == 0 && m[2:0] == 5)) e_dl = asz ? 2 : 4;
      if (e_dl > 0) begin e_dsp = p; p += e_dl; end
    end
    e_il = (ik == 1) ? 1 : (ik == 2) ? (osz ? 2 : 4) : 0;
    if (e_il > 0) begin e_imm = p; p += e_il; end
    e_len = p;
  endtask

  task automatic push(input logic [7:0] b, input bit gaps);
    if (gaps && ($urandom % 4 == 0)) begin
      in_valid = 1'b0;
      @(posedge clk); #1;
      chk("R1 idle cycle gives no pulse", done_o | fault_o, 0);
    end
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Sends the buffer as one instruction and checks the outcome against the model.
  task automatic run_instr(input string tag, input bit gaps);
    int n;
    ref_decode();
    n = (e_len > 15) ? 16 : e_len;
    for (int i = 0; i < n; i++) begin
      push(ib[i], gaps);
      if (i < n - 1)
        chk({tag, " R8 no early pulse"}, done_o | fault_o, 0);
    end
    if (e_len > 15) begin
      chk({tag, " R9 fault raised"}, fault_o, 1);
      chk({tag, " R9 no done on fault"}, done_o, 0);
    end else begin
      chk({tag, " R8 done"}, done_o, 1);
      chk({tag, " R9 no fault"}, fault_o, 0);
      chk({tag, " R8 len"}, len_o, e_len);
      chk({tag, " R2 op_off"}, op_off_o, e_op);
      chk({tag, " R4 has_modrm"}, has_modrm_o, e_hm);
      chk({tag, " R5 modrm_off"}, modrm_off_o, e_mo);
      chk({tag, " R5 has_sib"}, has_sib_o, e_hs);
      chk({tag, " R5 sib_off"}, sib_off_o, e_sib);
      chk({tag, " R6 disp_len"}, disp_len_o, e_dl);
      chk({tag, " R6 disp_off"}, disp_off_o, e_dsp);
      chk({tag, " R7 imm_len"}, imm_len_o, e_il);
      chk({tag, " R7 imm_off"}, imm_off_o, e_imm);
    end
  endtask

  task automatic load(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
    for (int i = 0; i < 16; i++) ib[i] = 8'h00;
    ib[0] = b0; ib[1] = b1; ib[2] = b2; ib[3] = b3;
    ib[4] = b4; ib[5] = b5; ib[6] = b6; ib[7] = b7;
  endtask

  initial begin
    logic [7:0] opl [0:17];
    logic [7:0] pfl [0:10];
    void'($urandom(32'd20240517));
    opl = '{8'h01, 8'h04, 8'h05, 8'h80, 8'h81, 8'h83, 8'h89, 8'hB3, 8'hBA, 8'hC3,
            8'hC6, 8'hC7, 8'hE8, 8'hEB, 8'h90, 8'h0F, 8'h8B, 8'h3C};
    pfl = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3};
    #12;
    chk("R1 ready low in reset", in_ready, 0);
    chk("R11 done low in reset", done_o, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R11 done after reset", done_o, 0);
    chk("R11 fault after reset", fault_o, 0);
    chk("R11 len after reset", len_o, 0);
    chk("R11 offsets after reset", op_off_o | modrm_off_o | imm_off_o, 0);
    chk("R1 ready after reset", in_ready, 1);

    // R4 single byte, 1-byte and full immediates
    load(8'h90, 0, 0, 0, 0, 0, 0, 0);            run_instr("R4 single", 0);
    load(8'h04, 8'h7F, 0, 0, 0, 0, 0, 0);        run_instr("R4 imm8", 0);
    load(8'hB8, 1, 2, 3, 4, 0, 0, 0);            run_instr("R4 immz", 0);
    // R2 stacked prefixes
    load(8'h66, 8'hF3, 8'h2E, 8'h90, 0, 0, 0, 0); run_instr("R2 prefixes", 0);
    // R3 escape with immediate and with addressing byte
    load(8'h0F, 8'h84, 9, 9, 9, 9, 0, 0);        run_instr("R3 esc imm", 0);
    load(8'h0F, 8'hAF, 8'hC0, 0, 0, 0, 0, 0);    run_instr("R3 esc modrm", 0);
    // R5 scale-index without displacement, rm=5 with full displacement
    load(8'h8B, 8'h04, 8'h25, 0, 0, 0, 0, 0);    run_instr("R5 sib", 0);
    load(8'h8B, 8'h05, 1, 2, 3, 4, 0, 0);        run_instr("R5 rm5", 0);
    // R6 address-size prefix halves the displacement
    load(8'h67, 8'h8B, 8'h85, 1, 2, 0, 0, 0);    run_instr("R6 adsz", 0);
    // R7 operand-size prefix halves the immediate, with sib and disp8
    load(8'h66, 8'hC7, 8'h44, 8'h24, 8'h08, 5, 6, 0); run_instr("R7 opsz", 0);

    // R9 exactly 15 bytes completes
    for (int i = 0; i < 16; i++) ib[i] = (i < 14) ? 8'hF0 : 8'h90;
    run_instr("R9 len15", 0);
    // R9 16 bytes of prefixes and opcode faults; R10 then decodes afresh
    for (int i = 0; i < 16; i++) ib[i] = (i < 15) ? 8'h66 : 8'h90;
    run_instr("R9 pfx16", 0);
    load(8'hB8, 1, 2, 3, 4, 0, 0, 0);            run_instr("R10 after fault", 0);
    // R9 fault reached inside an immediate
    for (int i = 0; i < 16; i++) ib[i] = (i < 14) ? 8'h2E : (i == 14) ? 8'h05 : 8'h11;
    run_instr("R9 imm16", 0);
    load(8'hC3, 0, 0, 0, 0, 0, 0, 0);            run_instr("R10 after fault2", 0);

    // Random back-to-back instructions with valid gaps
    for (int k = 0; k < 400; k++) begin
      int np;
      for (int i = 0; i < 16; i++) ib[i] = 8'($urandom);
      np = ($urandom % 16 == 0) ? 10 + int'($urandom % 6) : int'($urandom % 5);
      for (int i = 0; i < np; i++) ib[i] = pfl[$urandom % 11];
      if ($urandom % 4 != 0) ib[np] = opl[$urandom % 18];
      if (ib[np] == 8'h0F && $urandom % 2 == 0) ib[np + 1] = 8'h80 + 8'($urandom % 16);
      run_instr("R10 random", 1);
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule